// File: doc/BRIEF.md
# Integer Arithmetic-Logic Unit with Stream Output

This block performs the integer operations of a small fixed three-operand RISC subset on 32-bit words: two-operand add and subtract, the bitwise AND, OR and NOR functions, logical shifts left and right by a 5-bit amount, and a signed set-less-than. Add, AND and set-less-than also have variants that take a 16-bit immediate in place of the second register operand. Each operation yields one 32-bit result and a flag that is high when that result is zero, which a branch unit can use for equality tests. Bitwise inversion has no operation of its own and is obtained as NOR against a zero operand.

The arithmetic is combinational. One result register sits behind it, with a valid/ready handshake on the request side and on the result side. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result shows up with `out_valid` in the following cycle. The result stays on the outputs until a cycle in which `out_ready` is high.

Back-pressure rules:
- `in_ready` is high whenever the result register is empty or is being emptied in the same cycle.
- A downstream stall therefore propagates to the request side combinationally, with no extra buffering.

Top module: `int_alu`

## Requirements
- R1: Select 0 returns `a + b` and select 1 returns `a - b`. Both wrap modulo 2^32 and raise no exception.
- R2: Selects 2, 3 and 4 return `a & b`, `a | b` and `~(a | b)`. NOR with `b` equal to zero therefore gives the bitwise complement of `a`.
- R3: Select 5 shifts `a` left and select 6 shifts `a` right, by `shamt` (0 to 31) bit positions. Vacated bit positions are filled with zeros in both directions.
- R4: Select 7 returns 1 when `a` is less than `b` as signed two's-complement numbers, and returns 0 otherwise.
- R5: Select 8 (add-immediate) returns `a` plus `imm`. Select 10 (set-less-than-immediate) compares `a` with `imm` as a signed value. In both cases the 16-bit `imm` is sign-extended to 32 bits.
- R6: Select 9 returns `a` ANDed with `imm`, where `imm` is zero-extended to 32 bits.
- R7: Selects 11 to 15 return a result of 0.
- R8: `out_zero` is high exactly when `out_result` equals 0.
- R9: `in_ready` equals `!out_valid || out_ready`. A request taken on an edge is presented with `out_valid` high after that edge, and results leave in the order the requests were taken.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_zero` keep their values.
- R11: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation select |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| in_imm | input | 16 | Immediate field |
| in_shamt | input | 5 | Shift amount |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 32 | Operation result |
| out_zero | output | 1 | Result equals zero |

## Verification
The bench builds the block with its default widths: 32-bit data, a 16-bit immediate and the resulting 5-bit shift amount. With these widths the following corners become reachable:
- signed overflow wrap at the 0x7FFFFFFF boundary;
- a shift by the full 31 positions;
- the sign bit of the immediate switching between sign and zero extension.

The result side is stalled on a random share of cycles, so every operation is also seen held under back-pressure and accepted on the same edge a result leaves.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLL  = 4'd5,
    OP_SRL  = 4'd6,
    OP_SLT  = 4'd7,
    OP_ADDI = 4'd8,
    OP_ANDI = 4'd9,
    OP_SLTI = 4'd10
  } alu_op_e;

  localparam int OP_W = 4;
endpackage

// File: rtl/alu_imm_ext.sv
module alu_imm_ext #(
  parameter int IMM_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic [IMM_W-1:0]  imm,
  input  logic              sign_mode,
  output logic [DATA_W-1:0] ext
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic fill;
  assign fill = sign_mode & imm[IMM_W-1];
  assign ext  = {{PAD_W{fill}}, imm};
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = 32,
  parameter bit LEFT   = 1'b1,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amount,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage [SH_W+1];

  assign stage[0] = din;

  for (genvar i = 0; i < SH_W; i++) begin : g_stage
    localparam int STEP = 1 << i;
    if (LEFT) begin : g_left
      assign stage[i+1] = amount[i] ? (stage[i] << STEP) : stage[i];
    end else begin : g_right
      assign stage[i+1] = amount[i] ? (stage[i] >> STEP) : stage[i];
    end
  end

  assign dout = stage[SH_W];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] result
);
  alu_op_e           op_e;
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] shl;
  logic [DATA_W-1:0] shr;
  logic              lt_reg;
  logic              lt_imm;

  assign op_e = alu_op_e'(op);

  alu_imm_ext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext (
    .imm       (imm),
    .sign_mode (op != OP_ANDI),
    .ext       (imm_ext)
  );

  alu_shifter #(.DATA_W(DATA_W), .LEFT(1'b1)) u_shl (
    .din    (a),
    .amount (shamt),
    .dout   (shl)
  );

  alu_shifter #(.DATA_W(DATA_W), .LEFT(1'b0)) u_shr (
    .din    (a),
    .amount (shamt),
    .dout   (shr)
  );

  assign lt_reg = $signed(a) < $signed(b);
  assign lt_imm = $signed(a) < $signed(imm_ext);

  always_comb begin
    case (op_e)
      OP_ADD:  result = a + b;
      OP_SUB:  result = a - b;
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_NOR:  result = ~(a | b);
      OP_SLL:  result = shl;
      OP_SRL:  result = shr;
      OP_SLT:  result = {{(DATA_W-1){1'b0}}, lt_reg};
      OP_ADDI: result = a + imm_ext;
      OP_ANDI: result = a & imm_ext;
      OP_SLTI: result = {{(DATA_W-1){1'b0}}, lt_imm};
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [IMM_W-1:0]  in_imm,
  input  logic [SH_W-1:0]   in_shamt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_zero
);
  logic [DATA_W-1:0] core_res;
  logic              take;

  alu_core #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_core (
    .op     (in_op),
    .a      (in_a),
    .b      (in_b),
    .imm    (in_imm),
    .shamt  (in_shamt),
    .result (core_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_zero   <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= core_res;
      out_zero   <= (core_res == '0);
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [OP_W-1:0]   in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_zero
);
  // R10
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_zero)));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_result == '0)));

  // R9
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R4
  slt_binary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_op == OP_SLT || in_op == OP_SLTI))
      |=> (out_result[DATA_W-1:1] == '0));

  // R7
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op > OP_SLTI) |=> (out_result == '0 && out_zero));

  // R11
  reset_empty_chk: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_zero   (out_zero)
);

// File: tb/int_alu_test.sv
module int_alu_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_shamt = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_result;
  logic        out_zero;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] q_res [$];
  string       q_tag [$];

  always #(PERIOD/2) clk = ~clk;

  int_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .in_shamt(in_shamt), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_zero(out_zero)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [15:0] imm,
                                        input logic [4:0] sh);
    logic [31:0] sx = {{16{imm[15]}}, imm};
    logic [31:0] zx = {16'h0000, imm};
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a & b;
      4'd3:  return a | b;
      4'd4:  return ~(a | b);
      4'd5:  return a << sh;
      4'd6:  return a >> sh;
      4'd7:  return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd8:  return a + sx;
      4'd9:  return a & zx;
      4'd10: return ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:        return "R1";
      4'd2, 4'd3, 4'd4:  return "R2";
      4'd5, 4'd6:        return "R3";
      4'd7:              return "R4";
      4'd8, 4'd10:       return "R5";
      4'd9:              return "R6";
      default:           return "R7";
    endcase
  endfunction

  // One bench cycle: check outputs, pick ready, drive a request.
  task automatic cycle(input bit v, input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm,
                       input logic [4:0] sh, input int stall_pct, output bit acc);
    bit r;
    bit ov;
    @(negedge clk);
    ov = out_valid;
    check("R9 valid", {31'b0, out_valid}, {31'b0, q_res.size() != 0});
    if (ov && q_res.size() != 0) begin
      check(out_ready ? q_tag[0] : {q_tag[0], " R10"}, out_result, q_res[0]);
      check("R8", {31'b0, out_zero}, {31'b0, q_res[0] == 32'd0});
    end
    r = ($urandom % 100) >= stall_pct;
    out_ready = r;
    if (ov && r && q_res.size() != 0) begin
      void'(q_res.pop_front());
      void'(q_tag.pop_front());
    end
    acc = v && (!ov || r);
    in_valid = v;
    in_op = op; in_a = a; in_b = b; in_imm = imm; in_shamt = sh;
    if (acc) begin
      q_res.push_back(model(op, a, b, imm, sh));
      q_tag.push_back(tag_of(op));
    end
    #1;
    check("R9 ready", {31'b0, in_ready}, {31'b0, !ov || r});
  endtask

  task automatic send(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [15:0] imm, input logic [4:0] sh);
    bit acc = 1'b0;
    while (!acc) cycle(1'b1, op, a, b, imm, sh, 30, acc);
  endtask

  initial begin
    bit dummy;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 valid", {31'b0, out_valid}, 32'd0);
    check("R11 ready", {31'b0, in_ready}, 32'd1);
    rst_n = 1'b1;

    send(4'd0, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0);      // R1 wrap to sign
    send(4'd0, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);      // R1 wrap to zero, R8
    send(4'd1, 32'd5, 32'd5, 16'h0, 5'd0);              // R1 sub to zero
    send(4'd1, 32'd0, 32'd1, 16'h0, 5'd0);              // R1 borrow wrap
    send(4'd4, 32'h0F0F_1234, 32'd0, 16'h0, 5'd0);      // R2 NOT via NOR
    send(4'd2, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 16'h0, 5'd0); // R2
    send(4'd3, 32'hF000_0000, 32'h0000_000F, 16'h0, 5'd0); // R2
    send(4'd5, 32'h0000_0003, 32'd0, 16'h0, 5'd31);     // R3 shift by 31
    send(4'd6, 32'h8000_0001, 32'd0, 16'h0, 5'd31);     // R3 logical right
    send(4'd6, 32'hDEAD_BEEF, 32'd0, 16'h0, 5'd0);      // R3 zero shift
    send(4'd7, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0);      // R4 -1 < 1
    send(4'd7, 32'd1, 32'hFFFF_FFFF, 16'h0, 5'd0);      // R4 1 < -1 false
    send(4'd7, 32'd9, 32'd9, 16'h0, 5'd0);              // R4 equal
    send(4'd8, 32'd10, 32'd0, 16'hFFFF, 5'd0);          // R5 sign-extend
    send(4'd10, 32'hFFFF_FFFE, 32'd0, 16'hFFFF, 5'd0);  // R5 -2 < -1
    send(4'd10, 32'd0, 32'd0, 16'h8000, 5'd0);          // R5 0 < -32768 false
    send(4'd9, 32'hFFFF_FFFF, 32'd0, 16'h8000, 5'd0);   // R6 zero-extend
    send(4'd9, 32'hFFFF_FFFF, 32'd0, 16'hFFFF, 5'd0);   // R6
    for (int k = 11; k < 16; k++)
      send(4'(k), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 5'd7); // R7

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] op = 4'($urandom % 16);
      logic [31:0] a = $urandom;
      logic [31:0] b = ($urandom % 8 == 0) ? a : $urandom;
      bit v = ($urandom % 4) != 0;
      bit acc;
      cycle(v, op, a, b, 16'($urandom), 5'($urandom), 40, acc);
    end

    for (int n = 0; n < 6; n++) cycle(1'b0, 4'd0, 32'd0, 32'd0, 16'h0, 5'd0, 0, dummy);
    check("R9 drained", q_res.size(), 32'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule